// File: doc/BRIEF.md
# Transmit Line Bit-Error Monitor

This block sits beside a serial transmitter and reads back the level on the receive pin while a bit is being driven. If the level it reads differs from the bit being sent, it sets a sticky error flag. Software can use this flag to detect a collision or a damaged line. The flag stays set until software clears it.

A 16x oversampling tick divides each bit into sixteen numbered ticks. A bit-boundary strobe restarts the numbering. A two-bit mode field chooses where in the bit the line is read. One code reads it mid-bit and another reads it late in the bit. The other two codes turn the check off.

A small register interface reaches the mode field. The same control register also holds a break-detect enable, which the block passes straight out to the break-detect circuitry. The control register is reachable only while the alternate-map select input is high. The status register is always reachable.

Top module: `uart_tx_biterr_mon`

## Requirements
- R1: After reset the control register reads 0x00, `brk_en` is 0, `bit_err` is 0 and the status register reads 0x00.
- R2: The control register is at address 0x2. Bits 2:1 hold the mode code and bit 0 holds the break-detect enable. Bits 7:3 always read 0. `brk_en` follows bit 0.
- R3: When `alt_map` is 0, writes to address 0x2 are ignored and reads from address 0x2 return 0x00.
- R4: With mode code 01, the receive level is compared with `tx_bit` on tick 9 of the bit.
- R5: With mode code 10, the receive level is compared with `tx_bit` on tick 13 of the bit.
- R6: Mode codes 00 and 11 never set the error flag.
- R7: A `bit_start` pulse resets the tick number. The first `tick16` after it is tick 1. A tick that arrives in the same cycle as `bit_start` is not counted. The tick count saturates at 16.
- R8: The comparison counts only when `tx_active` is 1 on the sampling tick.
- R9: The error flag is sticky. It appears on `bit_err` and on bit 0 of the status register at address 0x3. Writing 1 to that bit clears the flag and writing 0 has no effect. If an error is detected in the same cycle as a clear, the flag stays set.
- R10: `rx_pin` passes through a two-flop synchronizer. A level applied one clock before the sampling tick's cycle is not seen. A level applied two clocks before it is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| bit_start | input | 1 | One-cycle strobe at each bit boundary |
| tx_active | input | 1 | High while the transmitter is driving a frame |
| tx_bit | input | 1 | Bit value currently being driven |
| rx_pin | input | 1 | Receive line, asynchronous |
| alt_map | input | 1 | Alternate-map select; gates control register access |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| bit_err | output | 1 | Sticky bit-error flag |
| brk_en | output | 1 | Break-detect enable |

## Verification
The flag rises at the clock edge that ends the cycle of the selected tick. The bench therefore reads the flag at least one falling edge after that tick pulse. Register writes take effect at the edge that closes the write cycle. Reads are combinational, so the bench samples them shortly after a falling edge with the address already stable. Receive levels are normally applied four clocks before each tick. The synchronizer test is the exception: it moves the level to one clock and then two clocks before the tick cycle, and checks that the two-flop latency is honoured exactly.

// File: rtl/biterr_pkg.sv
package biterr_pkg;

    typedef enum logic [1:0] {
        BEM_OFF  = 2'b00,
        BEM_MID  = 2'b01,
        BEM_LATE = 2'b10,
        BEM_RSVD = 2'b11
    } bem_mode_e;

    localparam int REG_W = 8;

endpackage

// File: rtl/biterr_sync.sv
module biterr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/biterr_sampler.sv
module biterr_sampler
    import biterr_pkg::*;
#(
    parameter int TICKS     = 16,
    parameter int MID_TICK  = 9,
    parameter int LATE_TICK = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick16,
    input  logic      bit_start,
    input  logic      tx_active,
    input  logic      tx_bit,
    input  logic      rx_sync,
    input  bem_mode_e mode,
    output logic      err_hit
);

    localparam int CNT_W = $clog2(TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } smp_state_t;

    smp_state_t       st_d, st_q;
    logic [CNT_W-1:0] tick_idx;
    logic [CNT_W-1:0] target;
    logic             sample_now;

    always_comb begin
        st_d = st_q;
        // number this tick would carry; saturates at the last tick
        tick_idx = (st_q.cnt == CNT_W'(TICKS)) ? CNT_W'(TICKS) : st_q.cnt + 1'b1;
        case (mode)
            BEM_MID:  target = CNT_W'(MID_TICK);
            BEM_LATE: target = CNT_W'(LATE_TICK);
            default:  target = '0;
        endcase
        if (bit_start) begin
            st_d.cnt = '0;
        end else if (tick16) begin
            st_d.cnt = tick_idx;
        end
        sample_now = tick16 && !bit_start && (target != '0) && (tick_idx == target);
        err_hit    = sample_now && tx_active && (rx_sync != tx_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r7_restart : assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |=> (st_q.cnt == '0));

    a_r7_saturate : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(TICKS));

endmodule

// File: rtl/biterr_regs.sv
module biterr_regs
    import biterr_pkg::*;
#(
    parameter int          ADDR_W    = 3,
    parameter logic [31:0] CTRL_ADDR = 32'h2,
    parameter logic [31:0] STAT_ADDR = 32'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_map,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              err_hit,
    output logic [REG_W-1:0]  bus_rdata,
    output bem_mode_e         mode,
    output logic              brk_en,
    output logic              flag
);

    typedef struct packed {
        bem_mode_e mode;
        logic      brk;
        logic      flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit_ctrl, hit_stat, ctrl_wr, clr_req;

    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
        hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
        ctrl_wr  = bus_we && hit_ctrl && alt_map;
        clr_req  = bus_we && hit_stat && bus_wdata[0];

        st_d = st_q;
        if (ctrl_wr) begin
            st_d.mode = bem_mode_e'(bus_wdata[2:1]);
            st_d.brk  = bus_wdata[0];
        end
        // a fresh error outranks a clear in the same cycle
        if (err_hit)      st_d.flag = 1'b1;
        else if (clr_req) st_d.flag = 1'b0;

        bus_rdata = '0;
        if (hit_ctrl && alt_map) bus_rdata = {{(REG_W-3){1'b0}}, st_q.mode, st_q.brk};
        else if (hit_stat)       bus_rdata = {{(REG_W-1){1'b0}}, st_q.flag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: BEM_OFF, brk: 1'b0, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign mode   = st_q.mode;
    assign brk_en = st_q.brk;
    assign flag   = st_q.flag;

    a_r3_unmapped_write : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ctrl && !alt_map) |=> ($stable(st_q.mode) && $stable(st_q.brk)));

    a_r9_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_req) |=> st_q.flag);

    a_r9_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> st_q.flag);

    a_r2_reserved_zero : assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> (bus_rdata[REG_W-1:3] == '0));

endmodule

// File: rtl/uart_tx_biterr_mon.sv
module uart_tx_biterr_mon
    import biterr_pkg::*;
#(
    parameter int TICKS     = 16,
    parameter int MID_TICK  = 9,
    parameter int LATE_TICK = 13,
    parameter int SYNC_LEN  = 2,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              bit_start,
    input  logic              tx_active,
    input  logic              tx_bit,
    input  logic              rx_pin,
    input  logic              alt_map,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bit_err,
    output logic              brk_en
);

    logic      rx_sync;
    logic      err_hit;
    bem_mode_e mode;

    biterr_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_pin),
        .dout (rx_sync)
    );

    biterr_sampler #(.TICKS(TICKS), .MID_TICK(MID_TICK), .LATE_TICK(LATE_TICK)) i_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .bit_start(bit_start),
        .tx_active(tx_active),
        .tx_bit   (tx_bit),
        .rx_sync  (rx_sync),
        .mode     (mode),
        .err_hit  (err_hit)
    );

    biterr_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_map  (alt_map),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .err_hit  (err_hit),
        .bus_rdata(bus_rdata),
        .mode     (mode),
        .brk_en   (brk_en),
        .flag     (bit_err)
    );

    // R6 / R8: the flag only rises after an enabled mode saw an active transmitter
    a_r6_rise_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_err) |-> ($past(tx_active) && ($past(mode) == BEM_MID || $past(mode) == BEM_LATE)));

endmodule

// File: tb/test_uart_tx_biterr_mon.sv
module test_uart_tx_biterr_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0, bit_start = 1'b0, tx_active = 1'b0, tx_bit = 1'b1;
    logic       rx_pin = 1'b1, alt_map = 1'b1, bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       bit_err, brk_en;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_tx_biterr_mon i_uart_tx_biterr_mon (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .bit_start(bit_start),
        .tx_active(tx_active), .tx_bit(tx_bit), .rx_pin(rx_pin), .alt_map(alt_map),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bit_err(bit_err), .brk_en(brk_en)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       tx;
        logic       rx_early;   // level for ticks 1..10
        logic       rx_late;    // level for ticks 11..16
        logic       act;
        logic       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 mid mismatch
        '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 late mismatch ignored
        '{2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 late mismatch
        '{2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 mid mismatch ignored
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R5
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 off
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 reserved
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R8 idle
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 idle
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R4
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}   // R4 match
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #2; d = bus_rdata;
    endtask

    task automatic tick_pulse();
        @(negedge clk); tick16 = 1'b1;
        @(negedge clk); tick16 = 1'b0;
    endtask

    task automatic send_ticks(input int n, input logic rxv);
        for (int i = 0; i < n; i++) begin
            rx_pin = rxv;
            repeat (3) @(negedge clk);
            tick_pulse();
        end
    endtask

    task automatic start_bit();
        @(negedge clk); bit_start = 1'b1;
        @(negedge clk); bit_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd2, rd); check(rd, 8'h00, "R1 ctrl");
        bus_read(3'd3, rd); check(rd, 8'h00, "R1 status");
        check({7'd0, brk_en}, 8'd0, "R1 brk_en");
        check({7'd0, bit_err}, 8'd0, "R1 bit_err");

        // R2 field layout and reserved bits
        bus_write(3'd2, 8'hFF);
        bus_read(3'd2, rd); check(rd, 8'h07, "R2 reserved read zero");
        check({7'd0, brk_en}, 8'd1, "R2 brk_en set");
        bus_write(3'd2, 8'h04);
        bus_read(3'd2, rd); check(rd, 8'h04, "R2 mode field");
        check({7'd0, brk_en}, 8'd0, "R2 brk_en clear");

        // R3 gated access
        alt_map = 1'b0;
        bus_write(3'd2, 8'h03);
        bus_read(3'd2, rd); check(rd, 8'h00, "R3 unmapped read");
        check({7'd0, brk_en}, 8'd0, "R3 unmapped write brk");
        alt_map = 1'b1;
        bus_read(3'd2, rd); check(rd, 8'h04, "R3 unmapped write ignored");

        // vector table: R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            bus_write(3'd2, {5'd0, VEC[v].mode, 1'b0});
            bus_write(3'd3, 8'h01);
            tx_bit = VEC[v].tx; tx_active = VEC[v].act;
            start_bit();
            send_ticks(10, VEC[v].rx_early);
            send_ticks(6, VEC[v].rx_late);
            @(negedge clk);
            check({7'd0, bit_err}, {7'd0, VEC[v].exp}, $sformatf("R4/R5/R6/R8 vector %0d", v));
        end

        // R9 sticky and write-1-to-clear
        tx_active = 1'b1; tx_bit = 1'b1;
        bus_write(3'd2, 8'h02);
        bus_write(3'd3, 8'h01);
        start_bit(); send_ticks(16, 1'b0);
        start_bit(); send_ticks(16, 1'b1);
        bus_read(3'd3, rd); check(rd, 8'h01, "R9 sticky after good bit");
        bus_write(3'd3, 8'h00);
        bus_read(3'd3, rd); check(rd, 8'h01, "R9 write zero no effect");
        bus_write(3'd3, 8'h01);
        bus_read(3'd3, rd); check(rd, 8'h00, "R9 write one clears");
        check({7'd0, bit_err}, 8'd0, "R9 port cleared");

        // R7 restart mid-bit
        start_bit(); send_ticks(6, 1'b1);
        start_bit(); send_ticks(8, 1'b1); send_ticks(1, 1'b0); send_ticks(7, 1'b1);
        @(negedge clk);
        check({7'd0, bit_err}, 8'd1, "R7 strobe restarts count");
        bus_write(3'd3, 8'h01);

        // R7 tick coincident with strobe is not counted
        rx_pin = 1'b1; repeat (3) @(negedge clk);
        @(negedge clk); bit_start = 1'b1; tick16 = 1'b1;
        @(negedge clk); bit_start = 1'b0; tick16 = 1'b0;
        send_ticks(8, 1'b1); send_ticks(1, 1'b0); send_ticks(7, 1'b1);
        @(negedge clk);
        check({7'd0, bit_err}, 8'd1, "R7 coincident tick ignored");
        bus_write(3'd3, 8'h01);

        // R10 synchronizer latency, lead of one clock is not seen
        start_bit(); send_ticks(8, 1'b1);
        rx_pin = 1'b0; tick_pulse();
        rx_pin = 1'b1; send_ticks(7, 1'b1);
        @(negedge clk);
        check({7'd0, bit_err}, 8'd0, "R10 one clock lead unseen");
        // lead of two clocks is seen
        start_bit(); send_ticks(8, 1'b1);
        rx_pin = 1'b0; @(negedge clk); tick_pulse();
        rx_pin = 1'b1; send_ticks(7, 1'b1);
        @(negedge clk);
        check({7'd0, bit_err}, 8'd1, "R10 two clock lead seen");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule